// File: doc/BRIEF.md
# Dual-Threshold Thermal Comparator Controller

This block watches a digitized junction temperature and raises a thermal interrupt when the reading crosses a limit that software has programmed. The sensor is outside the block and arrives as an unsigned input word. A signed calibration offset is added to the raw reading first. The sum is clamped to the representable range.

Two limit registers each hold a level, a direction, an interrupt enable and a valid flag. A single magnitude comparator is shared between them. When both limits are valid, a sequencer alternates the comparator between the two. When only one is valid, it compares against that one alone. Before each sample the sequencer waits for a programmable settling count, and the result is then latched into a sticky status bit.

The interrupt is the registered OR of every valid limit whose status is set and whose enable is on. It stays high until software rewrites the limit register. Clearing the global enable parks the sequencer in idle and holds the interrupt low.

Top module: `thermal_cmp_ctrl`

## Requirements
- R1: Four registers are reached by a 2-bit address: 0 and 1 are the limit registers, 2 is control, and 3 is the offset. A read returns data with `rd_vld` high one cycle after `rd_en`. Every register reads zero after reset, and the interrupt is low after reset.
- R2: The adjusted temperature is the raw 8-bit reading plus the sign-extended 6-bit offset held in offset register bits [5:0]. The result is clamped to the range 0..255.
- R3: A limit register holds its level in bits [7:0], its direction in bit 8, its interrupt enable in bit 9 and its valid flag in bit 10. Bit 11 reads back the status bit and cannot be written. With direction 1 the condition is adjusted > level; with direction 0 it is adjusted < level.
- R4: When exactly one limit is valid, only that limit is compared, and it is compared repeatedly.
- R5: When both limits are valid, the comparator alternates between them, and each limit's status reflects its own condition.
- R6: Control bit 0 is the global enable and bits [12:1] are the sample time S. After the enable is set, no status bit is set before S settling cycles have passed.
- R7: A status bit is set when a sample of its limit meets the condition. Once set, it stays set. Any write to that limit register clears it.
- R8: The interrupt is high exactly when the unit is enabled and at least one valid limit has its status and its interrupt enable both set. With its enable clear, a limit may set its status without raising the interrupt.
- R9: While the unit is disabled, no samples are taken, no status bit is set, and the interrupt is low. Status bits that were already set are kept.
- R10: A limit whose valid flag is clear is never compared, so its status stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| rd_vld | output | 1 | Read data valid |
| temp_raw | input | 8 | Digitized sensor reading |
| irq | output | 1 | Thermal interrupt |

## Verification
Several rules are checked by assertions on every cycle:
- The interrupt stays low while the unit is disabled or while no enabled, valid status bit is set.
- A status bit rises only in the cycle after a sample of its own limit.
- The sequencer takes no sample while disabled.
- With a zero offset, the adjusted value follows the raw reading.

Other behaviour can only be shown by the bench scenarios:
- The clamping at both ends of the range, and the direction encoding.
- Alternation of the comparator in dual mode.
- The length of the settling delay.
- Clearing of a status bit by a register write.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;

  localparam logic [1:0] ADDR_LIM0 = 2'd0;
  localparam logic [1:0] ADDR_LIM1 = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_OFFS = 2'd3;
endpackage

// File: rtl/thermal_adjust.sv
module thermal_adjust #(
  parameter int TW = 8,
  parameter int OW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TW-1:0]        raw_i,
  input  logic [OW-1:0]        off_i,
  output logic [TW-1:0]        adj_o
);
  localparam int EW = TW + 2;

  logic signed [EW-1:0] sum;
  logic [TW-1:0]        clamped;

  always_comb begin
    sum = $signed({2'b00, raw_i}) + $signed({{(EW-OW){off_i[OW-1]}}, off_i});
    if (sum < 0)
      clamped = '0;
    else if (sum > $signed({2'b00, {TW{1'b1}}}))
      clamped = {TW{1'b1}};
    else
      clamped = sum[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) adj_o <= '0;
    else     adj_o <= clamped;
  end

  // R2
  zero_offset_passthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (off_i == '0) |=> (adj_o == $past(raw_i)));
endmodule

// File: rtl/thermal_cmp.sv
module thermal_cmp #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] level_i,
  input  logic          above_i,
  output logic          met_o
);
  always_comb begin
    if (above_i) met_o = (temp_i > level_i);
    else         met_o = (temp_i < level_i);
  end
endmodule

// File: rtl/thermal_seq.sv
module thermal_seq
  import thermal_pkg::*;
#(
  parameter int SCW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic [1:0]     vld_i,
  input  logic [SCW-1:0] stime_i,
  output logic           smp_o,
  output logic           smp_sel_o
);
  seq_state_t     state_q;
  logic           sel_q;
  logic [SCW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || (vld_i == 2'b00)) begin
      state_q   <= SEQ_IDLE;
      sel_q     <= 1'b0;
      cnt_q     <= '0;
      smp_o     <= 1'b0;
      smp_sel_o <= 1'b0;
    end else if (!vld_i[sel_q]) begin
      state_q <= SEQ_WAIT;
      sel_q   <= ~sel_q;
      cnt_q   <= '0;
      smp_o   <= 1'b0;
    end else if (state_q == SEQ_WAIT && cnt_q >= stime_i) begin
      smp_o     <= 1'b1;
      smp_sel_o <= sel_q;
      cnt_q     <= '0;
      if (vld_i[~sel_q]) sel_q <= ~sel_q;
    end else begin
      state_q <= SEQ_WAIT;
      smp_o   <= 1'b0;
      if (state_q == SEQ_WAIT) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  no_sample_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !smp_o);
endmodule

// File: rtl/thermal_cmp_ctrl.sv
module thermal_cmp_ctrl
  import thermal_pkg::*;
#(
  parameter int TW  = 8,
  parameter int OW  = 6,
  parameter int SCW = 12,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  input  logic [TW-1:0] temp_raw,
  output logic          irq
);
  localparam int NLIM    = 2;
  localparam int B_DIR   = TW;
  localparam int B_IE    = TW + 1;
  localparam int B_VLD   = TW + 2;
  localparam int B_STAT  = TW + 3;

  logic [TW-1:0]  lvl_q [NLIM];
  logic [NLIM-1:0] dir_q, ie_q, vld_q, stat_q;
  logic           en_q;
  logic [SCW-1:0] stime_q;
  logic [OW-1:0]  off_q;

  logic [TW-1:0]  adj;
  logic           smp, smp_sel, met;

  thermal_adjust #(.TW(TW), .OW(OW)) u_adj (
    .clk(clk), .rst(rst), .raw_i(temp_raw), .off_i(off_q), .adj_o(adj));

  thermal_seq #(.SCW(SCW)) u_seq (
    .clk(clk), .rst(rst), .en_i(en_q), .vld_i(vld_q), .stime_i(stime_q),
    .smp_o(smp), .smp_sel_o(smp_sel));

  thermal_cmp #(.TW(TW)) u_cmp (
    .temp_i(adj), .level_i(lvl_q[smp_sel]), .above_i(dir_q[smp_sel]),
    .met_o(met));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      stime_q <= '0;
      off_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL) begin
        en_q    <= wr_data[0];
        stime_q <= wr_data[SCW:1];
      end
      if (wr_addr == ADDR_OFFS) off_q <= wr_data[OW-1:0];
    end
  end

  for (genvar i = 0; i < NLIM; i++) begin : g_lim
    logic hit;
    assign hit = wr_en && (wr_addr == 2'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[i]  <= '0;
        dir_q[i]  <= 1'b0;
        ie_q[i]   <= 1'b0;
        vld_q[i]  <= 1'b0;
        stat_q[i] <= 1'b0;
      end else if (hit) begin
        lvl_q[i]  <= wr_data[TW-1:0];
        dir_q[i]  <= wr_data[B_DIR];
        ie_q[i]   <= wr_data[B_IE];
        vld_q[i]  <= wr_data[B_VLD];
        stat_q[i] <= 1'b0;
      end else if (smp && (smp_sel == 1'(i)) && vld_q[i] && met) begin
        stat_q[i] <= 1'b1;
      end
    end

    // R7
    status_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_q[i]) |-> $past(smp && (smp_sel == 1'(i))));
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en_q && |(stat_q & ie_q & vld_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        rd_data <= '0;
        case (rd_addr)
          ADDR_LIM0, ADDR_LIM1: begin
            rd_data[TW-1:0] <= lvl_q[rd_addr[0]];
            rd_data[B_DIR]  <= dir_q[rd_addr[0]];
            rd_data[B_IE]   <= ie_q[rd_addr[0]];
            rd_data[B_VLD]  <= vld_q[rd_addr[0]];
            rd_data[B_STAT] <= stat_q[rd_addr[0]];
          end
          ADDR_CTRL: begin
            rd_data[0]     <= en_q;
            rd_data[SCW:1] <= stime_q;
          end
          default: rd_data[OW-1:0] <= off_q;
        endcase
      end
    end
  end

  // R9
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !irq);

  // R8
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ie_q & vld_q) == '0) |=> !irq);
endmodule

// File: tb/tb_thermal_cmp_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_cmp_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        rd_vld, irq;
  logic [7:0]  temp_raw;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  thermal_cmp_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld(rd_vld),
    .temp_raw(temp_raw), .irq(irq));

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_vld && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", it.tag, rd_data, it.exp);
      end
    end
  end

  function automatic logic [31:0] lim(bit v, bit ie, bit dir, logic [7:0] lvl, bit st);
    return {20'd0, st, v, ie, dir, lvl};
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(logic [1:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(bit e, string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  task automatic quiesce();
    wr(2'd2, 32'd0);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1): run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    temp_raw = 8'd0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);

    // R1 reset state
    chk_irq(1'b0, "R1 reset irq");
    for (int a = 0; a < 4; a++) rd_expect(2'(a), 32'd0, "R1 reset value");

    // R1 register round trip
    wr(2'd0, lim(1, 1, 0, 8'h5A, 0));
    wr(2'd1, lim(0, 1, 1, 8'hA5, 0));
    wr(2'd2, (32'd300 << 1));
    wr(2'd3, 32'h0000_0036);
    rd_expect(2'd0, lim(1, 1, 0, 8'h5A, 0), "R1 limit0 readback");
    rd_expect(2'd1, lim(0, 1, 1, 8'hA5, 0), "R1 limit1 readback");
    rd_expect(2'd2, (32'd300 << 1), "R1 control readback");
    rd_expect(2'd3, 32'h36, "R1 offset readback");
    quiesce();

    // R4 / R3 single mode, above
    temp_raw = 8'd120;
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wr(2'd2, (32'd4 << 1) | 1);
    wait_cyc(40);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 1), "R4 single status set");
    chk_irq(1'b1, "R8 irq raised");

    // R7 sticky, then cleared by rewrite
    temp_raw = 8'd50;
    wait_cyc(40);
    chk_irq(1'b1, "R7 irq held after condition gone");
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 1), "R7 status sticky");
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wait_cyc(40);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 0), "R7 status cleared by write");
    chk_irq(1'b0, "R7 irq cleared");

    // R3 below direction
    wr(2'd0, lim(1, 1, 0, 8'd60, 0));
    wait_cyc(40);
    rd_expect(2'd0, lim(1, 1, 0, 8'd60, 1), "R3 below met");
    quiesce();

    // R5 dual mode
    temp_raw = 8'd30;
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wr(2'd1, lim(1, 1, 0, 8'd40, 0));
    wr(2'd2, (32'd4 << 1) | 1);
    wait_cyc(60);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 0), "R5 dual limit0 not met");
    rd_expect(2'd1, lim(1, 1, 0, 8'd40, 1), "R5 dual limit1 met");
    chk_irq(1'b1, "R5 dual irq");
    temp_raw = 8'd120;
    wait_cyc(3);
    wr(2'd1, lim(1, 1, 0, 8'd40, 0));
    wait_cyc(60);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 1), "R5 dual limit0 met");
    rd_expect(2'd1, lim(1, 1, 0, 8'd40, 0), "R5 dual limit1 not met");
    quiesce();

    // R8 interrupt enable clear
    temp_raw = 8'd120;
    wr(2'd0, lim(1, 0, 1, 8'd100, 0));
    wr(2'd2, (32'd2 << 1) | 1);
    wait_cyc(30);
    rd_expect(2'd0, lim(1, 0, 1, 8'd100, 1), "R8 status without ie");
    chk_irq(1'b0, "R8 no irq without ie");
    quiesce();

    // R9 disabled
    temp_raw = 8'd120;
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wr(2'd2, (32'd2 << 1));
    wait_cyc(40);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 0), "R9 no sample while off");
    chk_irq(1'b0, "R9 irq low while off");
    wr(2'd2, (32'd2 << 1) | 1);
    wait_cyc(30);
    chk_irq(1'b1, "R9 irq after enable");
    wr(2'd2, (32'd2 << 1));
    wait_cyc(3);
    chk_irq(1'b0, "R9 irq dropped on disable");
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 1), "R9 status kept while off");
    quiesce();

    // R6 sample time
    temp_raw = 8'd120;
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wr(2'd2, (32'd200 << 1) | 1);
    wait_cyc(50);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 0), "R6 no status before settle");
    chk_irq(1'b0, "R6 irq low before settle");
    wait_cyc(300);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 1), "R6 status after settle");
    quiesce();

    // R2 offset, positive and negative
    temp_raw = 8'd95;
    wr(2'd3, 32'h0A);
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wr(2'd2, (32'd2 << 1) | 1);
    wait_cyc(30);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 1), "R2 positive offset met");
    temp_raw = 8'd105;
    wr(2'd3, 32'h36);
    wait_cyc(3);
    wr(2'd0, lim(1, 1, 1, 8'd100, 0));
    wait_cyc(30);
    rd_expect(2'd0, lim(1, 1, 1, 8'd100, 0), "R2 negative offset not met");

    // R2 clamp high
    temp_raw = 8'd250;
    wr(2'd3, 32'h0A);
    wait_cyc(3);
    wr(2'd0, lim(1, 1, 1, 8'd254, 0));
    wait_cyc(30);
    rd_expect(2'd0, lim(1, 1, 1, 8'd254, 1), "R2 clamp at 255");

    // R2 clamp low
    temp_raw = 8'd3;
    wr(2'd3, 32'h36);
    wait_cyc(3);
    wr(2'd0, lim(1, 1, 0, 8'd1, 0));
    wait_cyc(30);
    rd_expect(2'd0, lim(1, 1, 0, 8'd1, 1), "R2 clamp at 0");
    quiesce();

    // R10 invalid limits
    temp_raw = 8'd120;
    wr(2'd0, lim(0, 1, 1, 8'd100, 0));
    wr(2'd1, lim(0, 1, 0, 8'd200, 0));
    wr(2'd2, (32'd2 << 1) | 1);
    wait_cyc(40);
    rd_expect(2'd0, lim(0, 1, 1, 8'd100, 0), "R10 invalid limit0 unchecked");
    rd_expect(2'd1, lim(0, 1, 0, 8'd200, 0), "R10 invalid limit1 unchecked");
    chk_irq(1'b0, "R10 no irq");

    wait_cyc(3);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending reads got %0d expected 0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule